// File: doc/BRIEF.md
# External Interrupt Pin Controller with Low-Power Wakeup

This block watches a group of external interrupt pins and turns them into interrupt requests for a CPU. Each pin is set up for one of four trigger kinds: held low, rising transition, falling transition, or any transition. Each pin also has an enable bit and a bit that sends its request to either the fast or the normal interrupt line. Edge-triggered pins pass through a two-flop synchroniser and set a sticky flag. Software clears that flag by writing a one to it. A low-level pin reports its live state with no flop on the path. That keeps the pin-to-request path working while every clock is stopped.

The block also drives a wake signal to the power-mode controller. Wake is raised only outside run mode. The fast request counts only when the fast-enable status input is set. The normal request counts only when both the interrupt-enable and exception-enable status inputs are set. In wait and doze modes any pending request can wake the CPU. In stop mode no clock reaches the pins, so edges are not detected. In that mode only enabled low-level pins can wake the CPU. A debug-port event input never causes a wake.

Top module: `pin_wake_ctrl`

## Requirements
- R1: After asynchronous reset, every flag is 0, every pin is disabled in level-low mode with normal routing, and no interrupt or wake output is raised even when a pin is driven low.
- R2: Per-pin trigger code (bits [2i+1:2i] of the mode word): 00 level low, 01 rising, 10 falling, 11 either. A matching transition sets the pin's sticky flag on the third rising clock edge after the pin changes.
- R3: A write to the clear address (3) clears each edge flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: For a level-low pin, the flag equals the inverted pin, with no clock needed. The pin requests an interrupt combinationally whenever it is low and enabled.
- R5: A disabled pin raises no request, but a matching edge still sets its flag.
- R6: A requesting pin drives irq_fast when its fast-select bit (address 2) is 1, and irq_norm when that bit is 0.
- R7: In run mode (power code 00), wake is 0 whatever requests are pending.
- R8: In wait (01) and doze (10), pending requests from edge pins and from level pins can both raise wake.
- R9: In stop (11), edges do not set flags, and only enabled level-low pins can raise wake. Edge flags set before stop do not wake.
- R10: A fast request contributes to wake only when st_fe is 1.
- R11: A normal request contributes to wake only when st_ie and st_ee are both 1.
- R12: The dbg_evt input never raises wake, in any power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (absent in stop mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | N_PINS | External interrupt pins |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | 0 mode word, 1 enable, 2 fast select, 3 flag clear |
| wr_data | input | 2*N_PINS | Write data (low N_PINS bits for addresses 1 to 3) |
| pwr_mode | input | 2 | 00 run, 01 wait, 10 doze, 11 stop |
| st_fe | input | 1 | CPU fast-interrupt enable status |
| st_ie | input | 1 | CPU interrupt enable status |
| st_ee | input | 1 | CPU exception enable status |
| dbg_evt | input | 1 | Debug-port event (never wakes) |
| flags | output | N_PINS | Per-pin flag view |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |
| wake | output | 1 | Wake request to the power-mode controller |

## Verification
The bench builds the block with N_PINS = 4. With four pins, one pin can hold each of the four trigger codes at the same time, so a single transition pattern checks all codes together, and a partial clear mask leaves a neighbour's flag set where it can be observed. Four pins also allow a level pin and a stale edge flag to be held together across stop mode, so the stop-mode filter is tested against a real alternative source.

// File: rtl/pin_wake_pkg.sv
package pin_wake_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_ANY  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_DOZE = 2'b10,
    PM_STOP = 2'b11
  } pmode_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_EN    = 2'd1;
  localparam logic [1:0] ADDR_FAST  = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;

  // does a synchronised transition match the trigger code
  function automatic logic edge_hit(logic [1:0] code, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (code)
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // wake qualification for one request class pair
  function automatic logic qualify(logic fast_any, logic norm_any,
                                   logic fe, logic ie, logic ee);
    qualify = (fast_any & fe) | (norm_any & ie & ee);
  endfunction
endpackage

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_wake_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [2*N_PINS-1:0]    wr_data,
  output logic [N_PINS-1:0][1:0] trig_q,
  output logic [N_PINS-1:0]      en_q,
  output logic [N_PINS-1:0]      fast_q,
  output logic [N_PINS-1:0]      clr_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      en_q   <= '0;
      fast_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MODE: trig_q <= wr_data;
        ADDR_EN:   en_q   <= wr_data[N_PINS-1:0];
        ADDR_FAST: fast_q <= wr_data[N_PINS-1:0];
        default:   ;
      endcase
    end
  end

  assign clr_mask = (wr_en && wr_addr == ADDR_CLEAR) ? wr_data[N_PINS-1:0] : '0;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(trig_q) && $stable(en_q) && $stable(fast_q)); // R1
endmodule

// File: rtl/pin_edge_cell.sv
module pin_edge_cell
  import pin_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] trig,
  input  logic       stop,
  input  logic       clr,
  output logic       flag_q,
  output logic       hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // with clocks stopped there is no edge detection
  assign hit = edge_hit(trig, s2_q, prev_q) & ~stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q); // R3
  AST_STOP_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !flag_q) |=> !flag_q); // R9
endmodule

// File: rtl/pin_wake_qual.sv
module pin_wake_qual
  import pin_wake_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] req_lvl,
  input  logic [N_PINS-1:0] req_all,
  input  logic [N_PINS-1:0] fast_sel,
  input  logic [1:0]        pwr_mode,
  input  logic              st_fe,
  input  logic              st_ie,
  input  logic              st_ee,
  input  logic              dbg_evt,
  output logic              irq_fast,
  output logic              irq_norm,
  output logic              wake
);
  logic [N_PINS-1:0] cand;
  logic              in_stop, in_run, cand_fast, cand_norm;

  assign in_stop   = (pwr_mode == PM_STOP);
  assign in_run    = (pwr_mode == PM_RUN);
  assign irq_fast  = |(req_all & fast_sel);
  assign irq_norm  = |(req_all & ~fast_sel);
  assign cand      = in_stop ? req_lvl : req_all;
  assign cand_fast = |(cand & fast_sel);
  assign cand_norm = |(cand & ~fast_sel);
  assign wake      = ~in_run & qualify(cand_fast, cand_norm, st_fe, st_ie, st_ee);

  AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> !wake); // R7
  AST_FAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !(st_ie && st_ee)) |-> (st_fe && irq_fast)); // R10
  AST_NORM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !st_fe) |-> (st_ie && st_ee && irq_norm)); // R11
  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && wake) |-> (req_lvl != '0)); // R9
  AST_DBG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_evt && req_all == '0) |-> !wake); // R12
endmodule

// File: rtl/pin_wake_ctrl.sv
module pin_wake_ctrl
  import pin_wake_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PINS-1:0]   pins_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [2*N_PINS-1:0] wr_data,
  input  logic [1:0]          pwr_mode,
  input  logic                st_fe,
  input  logic                st_ie,
  input  logic                st_ee,
  input  logic                dbg_evt,
  output logic [N_PINS-1:0]   flags,
  output logic                irq_norm,
  output logic                irq_fast,
  output logic                wake
);
  logic [N_PINS-1:0][1:0] trig_q;
  logic [N_PINS-1:0]      en_q, fast_q, clr_mask;
  logic [N_PINS-1:0]      edge_flag, edge_hit_w, is_lvl, req_lvl, req_all;
  logic                   stop_w;

  assign stop_w = (pwr_mode == PM_STOP);

  pin_cfg_regs #(.N_PINS(N_PINS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_q(trig_q), .en_q(en_q), .fast_q(fast_q),
    .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_edge_cell cell_i (
      .clk(clk), .rst_n(rst_n), .pin(pins_in[i]), .trig(trig_q[i]),
      .stop(stop_w), .clr(clr_mask[i]), .flag_q(edge_flag[i]),
      .hit(edge_hit_w[i])
    );
    // level path: no flop between pin and request
    assign is_lvl[i]  = (trig_q[i] == TRIG_LOW);
    assign flags[i]   = is_lvl[i] ? ~pins_in[i] : edge_flag[i];
    assign req_lvl[i] = is_lvl[i] & en_q[i] & ~pins_in[i];
    assign req_all[i] = en_q[i] & flags[i];
  end

  pin_wake_qual #(.N_PINS(N_PINS)) qual_i (
    .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .req_all(req_all),
    .fast_sel(fast_q), .pwr_mode(pwr_mode), .st_fe(st_fe), .st_ie(st_ie),
    .st_ee(st_ee), .dbg_evt(dbg_evt), .irq_fast(irq_fast),
    .irq_norm(irq_norm), .wake(wake)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !(irq_norm || irq_fast)); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit_w != '0) |=> ((edge_flag & $past(edge_hit_w)) == $past(edge_hit_w))); // R2
endmodule

// File: tb/pin_wake_ctrl_tb_top.sv
module pin_wake_ctrl_tb_top;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins_in = '1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [2*N-1:0] wr_data = 0;
  logic [1:0] pwr_mode = 0;
  logic st_fe = 0, st_ie = 0, st_ee = 0, dbg_evt = 0;
  logic [N-1:0] flags;
  logic irq_norm, irq_fast, wake;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_wake_ctrl #(.N_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwr_mode(pwr_mode),
    .st_fe(st_fe), .st_ie(st_ie), .st_ee(st_ee), .dbg_evt(dbg_evt),
    .flags(flags), .irq_norm(irq_norm), .irq_fast(irq_fast), .wake(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [2*N-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 flags", flags, 0);
    pins_in[0] = 0; #1;
    chk("R1 irq", {irq_norm, irq_fast, wake}, 0);
    pins_in[0] = 1; cyc(4);
  endtask

  task automatic t_level();
    wr(1, 8'h01);
    pins_in[0] = 0; #1;   // no clock edge in between
    chk("R4 flag low", flags[0], 1);
    chk("R4 req low", irq_norm, 1);
    pins_in[0] = 1; #1;
    chk("R4 flag high", flags[0], 0);
    chk("R4 req high", irq_norm, 0);
  endtask

  task automatic t_edges();
    // pin1 rise, pin2 fall, pin3 any
    wr(0, 8'b11_10_01_00);
    pins_in[3:1] = 3'b000; cyc(4);
    chk("R2 falling pattern", flags[3:1], 3'b110);
    wr(3, 8'h0E);
    chk("R3 cleared", flags[3:1], 3'b000);
    pins_in[3:1] = 3'b111; cyc(4);
    chk("R2 rising pattern", flags[3:1], 3'b101);
    wr(3, 8'h02);
    chk("R3 partial clear", flags[3:1], 3'b100);
    chk("R5 disabled no irq", {irq_norm, irq_fast}, 0);
    wr(1, 8'h08);
    chk("R5 enabled irq", irq_norm, 1);
  endtask

  task automatic t_route();
    wr(2, 8'h08);
    chk("R6 to fast", {irq_fast, irq_norm}, 2'b10);
    wr(2, 8'h00);
    chk("R6 to norm", {irq_fast, irq_norm}, 2'b01);
  endtask

  task automatic t_wake();
    st_ie = 1; st_ee = 1; pwr_mode = 0; #1;
    chk("R7 run", wake, 0);
    pwr_mode = 1; #1;
    chk("R8 wait edge", wake, 1);
    pwr_mode = 2; #1;
    chk("R8 doze edge", wake, 1);
    st_ee = 0; #1;
    chk("R11 ee off", wake, 0);
    st_ee = 1; st_ie = 0; #1;
    chk("R11 ie off", wake, 0);
    wr(2, 8'h08); st_fe = 0; #1;
    chk("R10 fe off", wake, 0);
    st_fe = 1; #1;
    chk("R10 fe on", wake, 1);
    wr(2, 8'h00); st_fe = 0; st_ie = 1;
    pwr_mode = 0; wr(3, 8'h0F); #1;
    chk("R8 cleared", wake, 0);
  endtask

  task automatic t_stop();
    wr(1, 8'h0B);           // pins 0,1,3 enabled
    pins_in[3] = 0; cyc(4); // pin3 flag set while running
    pwr_mode = 3; #1;
    chk("R9 stale edge no wake", wake, 0);
    pins_in[1] = 0; cyc(2); pins_in[1] = 1; cyc(5);
    chk("R9 no edge in stop", flags[1], 0);
    pins_in[0] = 0; #1;
    chk("R9 level wakes", wake, 1);
    pins_in[0] = 1; #1;
    chk("R9 level released", wake, 0);
    pwr_mode = 0; pins_in[3] = 1; cyc(4); wr(3, 8'h0F);
  endtask

  task automatic t_dbg();
    for (int m = 0; m < 4; m++) begin
      pwr_mode = m[1:0]; dbg_evt = 1; #1;
      chk("R12 dbg", wake, 0);
      dbg_evt = 0; #1;
    end
    pwr_mode = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    t_reset();
    t_level();
    t_edges();
    t_route();
    t_wake();
    t_stop();
    t_dbg();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule